// File: doc/BRIEF.md
# Microcontroller Parallel I/O Port Unit

This block holds the register side of three byte-wide parallel ports for an 8-bit microcontroller core. The core reaches it over a simple byte bus: an address, a write strobe with write data, and a read strobe with a select between reading the stored latch and reading the sampled pins. Each pin's drive is given as separate strong-low and strong-high enables. The second port also has a weak pull-up enable. The surrounding pad ring turns these enables into electrical behaviour.

Port A is an open-drain bidirectional port. While the external-access control is high, it becomes a push-pull driver for the low address/data byte, and during that time its latch is held at all ones. Port B has no output drive. Its latch bits select, pin by pin, between analog input use (bit set) and high-impedance digital input use (bit clear). Port C is a quasi-bidirectional port with weak pull-ups. During external access it drives either the middle or the high byte of a 24-bit address, chosen by a phase input.

Top module: `mcu_port_unit`

## Requirements
- R1: After reset the latches of all three ports read 0xFF, the external-access state is inactive, no strong drive enable of Port A or Port C is active, and all Port C weak pull-ups are on.
- R2: A write with the strobe high at address 0x80 (Port A), 0x90 (Port B) or 0xA0 (Port C) loads the write data into that latch at the next clock edge.
- R3: A read with the pin select low returns the addressed latch. A read with the pin select high returns the synchronized pin levels of that port.
- R4: The pin levels seen by a pin read follow a change at the pin inputs after exactly two clock edges.
- R5: With external access inactive, a Port A bit holding 1 drives neither high nor low. A bit holding 0 enables the strong-low driver.
- R6: With external access active, Port A drives push-pull from the address/data byte: the high enable equals the byte and the low enable equals its inverse.
- R7: In every cycle in which external access is active, the Port A latch is loaded with 0xFF. This takes priority over a CPU write to Port A.
- R8: Port B never drives its pins. Its analog-select outputs equal its latch, which is 0xFF after reset.
- R9: With external access inactive, a Port C bit holding 1 enables only the weak pull-up. A bit holding 0 enables only the strong-low driver.
- R10: With external access active, Port C turns its pull-ups off and drives push-pull the middle address byte when the phase input is 0, or the high address byte when it is 1.
- R11: The read data is 0x00 when the read strobe is low or the address matches no port.
- R12: A write and a read of the same latch in one cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sfrAddr | input | 8 | Register address |
| sfrWrEn | input | 1 | Write strobe |
| sfrWrData | input | 8 | Write data |
| sfrRdEn | input | 1 | Read strobe |
| sfrRdPin | input | 1 | 1 selects the pin levels, 0 selects the latch |
| sfrRdData | output | 8 | Read data |
| extAccess | input | 1 | External memory access in progress |
| extAddrData | input | 8 | Low address / data byte for Port A |
| extAddrMid | input | 8 | Middle address byte |
| extAddrHigh | input | 8 | High address byte |
| extPhase | input | 1 | Port C address phase: 0 middle, 1 high |
| portAPinIn | input | 8 | Port A pin levels |
| portBPinIn | input | 8 | Port B pin levels |
| portCPinIn | input | 8 | Port C pin levels |
| portADriveHigh | output | 8 | Port A strong-high enables |
| portADriveLow | output | 8 | Port A strong-low enables |
| portBAnalogSel | output | 8 | Port B analog-input selects |
| portCDriveHigh | output | 8 | Port C strong-high enables |
| portCDriveLow | output | 8 | Port C strong-low enables |
| portCPullUp | output | 8 | Port C weak pull-up enables |

## Verification
The assertions check four things in every cycle: the Port A latch is forced to all ones during external access, a write lands in the addressed latch, the high and low enables of one pin are never both on, and the read bus is quiet when no valid read is made. Some behaviour only the directed scenarios can show. These are the two-edge lag of pin reads, the choice of Port C address byte by phase, the return to float when external access ends, and the old value returned by a write and read in the same cycle.

// File: rtl/mcu_port_pkg.sv
package mcu_port_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int NUM_PORTS = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_A    = 2'd1,
    SEL_B    = 2'd2,
    SEL_C    = 2'd3
  } portSel_e;

  typedef struct packed {
    logic     wrA;
    logic     wrB;
    logic     wrC;
    logic     forceA;
    logic     extMode;
    logic     extHigh;
    portSel_e rdSel;
    logic     rdPin;
  } portStrobe_t;
endpackage

// File: rtl/mcu_port_sync.sv
module mcu_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mcu_port_ctrl.sv
module mcu_port_ctrl
  import mcu_port_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ADDR_A = 8'h80,
  parameter logic [ADDR_W-1:0] ADDR_B = 8'h90,
  parameter logic [ADDR_W-1:0] ADDR_C = 8'hA0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              sfrWrEn,
  input  logic              sfrRdEn,
  input  logic              sfrRdPin,
  input  logic              extAccess,
  input  logic              extPhase,
  output portStrobe_t       strb
);
  logic hitA, hitB, hitC;
  logic extActive;

  assign hitA = (sfrAddr == ADDR_A);
  assign hitB = (sfrAddr == ADDR_B);
  assign hitC = (sfrAddr == ADDR_C);

  // external access is only honoured once out of reset
  assign extActive = extAccess && rstN;

  always_comb begin
    strb         = '0;
    strb.wrA     = sfrWrEn && hitA && !extActive;
    strb.wrB     = sfrWrEn && hitB;
    strb.wrC     = sfrWrEn && hitC;
    strb.forceA  = extActive;
    strb.extMode = extActive;
    strb.extHigh = extPhase;
    strb.rdPin   = sfrRdPin;
    if (sfrRdEn) begin
      if (hitA)      strb.rdSel = SEL_A;
      else if (hitB) strb.rdSel = SEL_B;
      else if (hitC) strb.rdSel = SEL_C;
      else           strb.rdSel = SEL_NONE;
    end
  end

  // only one write strobe may fire at a time
  p_onehot_wr_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrA, strb.wrB, strb.wrC}));

  // the force and a CPU write to Port A never both act
  p_force_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceA |-> !strb.wrA);
endmodule

// File: rtl/mcu_port_dp.sv
module mcu_port_dp
  import mcu_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strb,
  input  logic [DATA_W-1:0] sfrWrData,
  output logic [DATA_W-1:0] sfrRdData,
  input  logic [DATA_W-1:0] extAddrData,
  input  logic [DATA_W-1:0] extAddrMid,
  input  logic [DATA_W-1:0] extAddrHigh,
  input  logic [DATA_W-1:0] portAPinIn,
  input  logic [DATA_W-1:0] portBPinIn,
  input  logic [DATA_W-1:0] portCPinIn,
  output logic [DATA_W-1:0] portADriveHigh,
  output logic [DATA_W-1:0] portADriveLow,
  output logic [DATA_W-1:0] portBAnalogSel,
  output logic [DATA_W-1:0] portCDriveHigh,
  output logic [DATA_W-1:0] portCDriveLow,
  output logic [DATA_W-1:0] portCPullUp
);
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  logic [DATA_W-1:0] latchA, latchB, latchC;
  logic [NUM_PORTS-1:0][DATA_W-1:0] pinRaw;
  logic [NUM_PORTS-1:0][DATA_W-1:0] pinSync;
  logic [DATA_W-1:0] cAddrByte;

  // latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchA <= ALL_ONES;
      latchB <= ALL_ONES;
      latchC <= ALL_ONES;
    end else begin
      if (strb.forceA)   latchA <= ALL_ONES;
      else if (strb.wrA) latchA <= sfrWrData;
      if (strb.wrB)      latchB <= sfrWrData;
      if (strb.wrC)      latchC <= sfrWrData;
    end
  end

  // pin synchronizers, one per port
  assign pinRaw[0] = portAPinIn;
  assign pinRaw[1] = portBPinIn;
  assign pinRaw[2] = portCPinIn;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gSync
    mcu_port_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rstN (rstN),
      .din  (pinRaw[g]),
      .dout (pinSync[g])
    );
  end

  // read mux
  always_comb begin
    unique case (strb.rdSel)
      SEL_A:   sfrRdData = strb.rdPin ? pinSync[0] : latchA;
      SEL_B:   sfrRdData = strb.rdPin ? pinSync[1] : latchB;
      SEL_C:   sfrRdData = strb.rdPin ? pinSync[2] : latchC;
      default: sfrRdData = '0;
    endcase
  end

  // Port A drive
  always_comb begin
    if (strb.extMode) begin
      portADriveHigh = extAddrData;
      portADriveLow  = ~extAddrData;
    end else begin
      portADriveHigh = '0;
      portADriveLow  = ~latchA;
    end
  end

  // Port B: analog select only
  assign portBAnalogSel = latchB;

  // Port C drive
  assign cAddrByte = strb.extHigh ? extAddrHigh : extAddrMid;

  always_comb begin
    if (strb.extMode) begin
      portCDriveHigh = cAddrByte;
      portCDriveLow  = ~cAddrByte;
      portCPullUp    = '0;
    end else begin
      portCDriveHigh = '0;
      portCDriveLow  = ~latchC;
      portCPullUp    = latchC;
    end
  end

  p_force_ones_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceA |=> (latchA == ALL_ONES));

  p_wr_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrC |=> (latchC == $past(sfrWrData)));

  p_no_fight_a_r6: assert property (@(posedge clk) disable iff (!rstN)
    (portADriveHigh & portADriveLow) == '0);

  p_io_float_a_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.extMode |-> (portADriveHigh == '0));

  p_pull_excl_c_r9: assert property (@(posedge clk) disable iff (!rstN)
    (portCPullUp & (portCDriveHigh | portCDriveLow)) == '0);

  p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == SEL_NONE) |-> (sfrRdData == '0));
endmodule

// File: rtl/mcu_port_unit.sv
module mcu_port_unit
  import mcu_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              sfrWrEn,
  input  logic [DATA_W-1:0] sfrWrData,
  input  logic              sfrRdEn,
  input  logic              sfrRdPin,
  output logic [DATA_W-1:0] sfrRdData,
  input  logic              extAccess,
  input  logic [DATA_W-1:0] extAddrData,
  input  logic [DATA_W-1:0] extAddrMid,
  input  logic [DATA_W-1:0] extAddrHigh,
  input  logic              extPhase,
  input  logic [DATA_W-1:0] portAPinIn,
  input  logic [DATA_W-1:0] portBPinIn,
  input  logic [DATA_W-1:0] portCPinIn,
  output logic [DATA_W-1:0] portADriveHigh,
  output logic [DATA_W-1:0] portADriveLow,
  output logic [DATA_W-1:0] portBAnalogSel,
  output logic [DATA_W-1:0] portCDriveHigh,
  output logic [DATA_W-1:0] portCDriveLow,
  output logic [DATA_W-1:0] portCPullUp
);
  portStrobe_t strb;

  mcu_port_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sfrAddr   (sfrAddr),
    .sfrWrEn   (sfrWrEn),
    .sfrRdEn   (sfrRdEn),
    .sfrRdPin  (sfrRdPin),
    .extAccess (extAccess),
    .extPhase  (extPhase),
    .strb      (strb)
  );

  mcu_port_dp #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .sfrWrData      (sfrWrData),
    .sfrRdData      (sfrRdData),
    .extAddrData    (extAddrData),
    .extAddrMid     (extAddrMid),
    .extAddrHigh    (extAddrHigh),
    .portAPinIn     (portAPinIn),
    .portBPinIn     (portBPinIn),
    .portCPinIn     (portCPinIn),
    .portADriveHigh (portADriveHigh),
    .portADriveLow  (portADriveLow),
    .portBAnalogSel (portBAnalogSel),
    .portCDriveHigh (portCDriveHigh),
    .portCDriveLow  (portCDriveLow),
    .portCPullUp    (portCPullUp)
  );
endmodule

// File: tb/test_mcu_port_unit.sv
`timescale 1ns/1ps
module test_mcu_port_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] sfrAddr = '0;
  logic       sfrWrEn = 1'b0;
  logic [7:0] sfrWrData = '0;
  logic       sfrRdEn = 1'b0;
  logic       sfrRdPin = 1'b0;
  logic [7:0] sfrRdData;
  logic       extAccess = 1'b0;
  logic [7:0] extAddrData = '0;
  logic [7:0] extAddrMid = '0;
  logic [7:0] extAddrHigh = '0;
  logic       extPhase = 1'b0;
  logic [7:0] portAPinIn = '0;
  logic [7:0] portBPinIn = '0;
  logic [7:0] portCPinIn = '0;
  logic [7:0] portADriveHigh, portADriveLow, portBAnalogSel;
  logic [7:0] portCDriveHigh, portCDriveLow, portCPullUp;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mcu_port_unit i_mcu_port_unit (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic sfrWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfrAddr = a; sfrWrData = d; sfrWrEn = 1'b1;
    @(negedge clk);
    sfrWrEn = 1'b0;
  endtask

  task automatic sfrRead(input logic [7:0] a, input logic pin, output logic [7:0] d);
    sfrAddr = a; sfrRdPin = pin; sfrRdEn = 1'b1;
    #1 d = sfrRdData;
    sfrRdEn = 1'b0; sfrRdPin = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    sfrRead(8'h80, 1'b0, d); chk("R1 latch A", d, 8'hFF);
    sfrRead(8'h90, 1'b0, d); chk("R1 latch B", d, 8'hFF);
    sfrRead(8'hA0, 1'b0, d); chk("R1 latch C", d, 8'hFF);
    chk("R1 A high", portADriveHigh, 8'h00);
    chk("R1 A low", portADriveLow, 8'h00);
    chk("R1 C low", portCDriveLow, 8'h00);
    chk("R1 C pullup", portCPullUp, 8'hFF);
    chk("R8 analog reset", portBAnalogSel, 8'hFF);
  endtask

  task automatic t_write_read();
    logic [7:0] d;
    sfrWrite(8'h80, 8'h5A);
    sfrWrite(8'h90, 8'h0F);
    sfrWrite(8'hA0, 8'hC3);
    sfrRead(8'h80, 1'b0, d); chk("R2 R3 latch A", d, 8'h5A);
    sfrRead(8'h90, 1'b0, d); chk("R2 R3 latch B", d, 8'h0F);
    sfrRead(8'hA0, 1'b0, d); chk("R2 R3 latch C", d, 8'hC3);
    chk("R5 A low", portADriveLow, 8'hA5);
    chk("R5 A high", portADriveHigh, 8'h00);
    chk("R9 C low", portCDriveLow, 8'h3C);
    chk("R9 C pullup", portCPullUp, 8'hC3);
    chk("R9 C high", portCDriveHigh, 8'h00);
    chk("R8 analog sel", portBAnalogSel, 8'h0F);
  endtask

  task automatic t_read_pin();
    logic [7:0] d;
    @(negedge clk);
    portAPinIn = 8'h96; portBPinIn = 8'h3E; portCPinIn = 8'h71;
    @(negedge clk);
    sfrRead(8'h80, 1'b1, d); chk("R4 A one edge", d, 8'h00);
    @(negedge clk);
    sfrRead(8'h80, 1'b1, d); chk("R4 R3 A pin", d, 8'h96);
    sfrRead(8'h90, 1'b1, d); chk("R3 B pin", d, 8'h3E);
    sfrRead(8'hA0, 1'b1, d); chk("R3 C pin", d, 8'h71);
    sfrRead(8'h80, 1'b0, d); chk("R3 A latch not pin", d, 8'h5A);
  endtask

  task automatic t_ext();
    logic [7:0] d;
    @(negedge clk);
    extAccess = 1'b1; extAddrData = 8'h3C; extAddrMid = 8'h12;
    extAddrHigh = 8'h34; extPhase = 1'b0;
    #1;
    chk("R6 A high", portADriveHigh, 8'h3C);
    chk("R6 A low", portADriveLow, 8'hC3);
    chk("R10 C mid high", portCDriveHigh, 8'h12);
    chk("R10 C mid low", portCDriveLow, 8'hED);
    chk("R10 C pullup off", portCPullUp, 8'h00);
    @(negedge clk);
    extPhase = 1'b1;
    #1;
    chk("R10 C high byte", portCDriveHigh, 8'h34);
    chk("R10 C high low", portCDriveLow, 8'hCB);
    sfrWrite(8'h80, 8'h00);
    extAccess = 1'b0;
    #1;
    sfrRead(8'h80, 1'b0, d); chk("R7 A latch forced", d, 8'hFF);
    chk("R5 A float high", portADriveHigh, 8'h00);
    chk("R5 A float low", portADriveLow, 8'h00);
    chk("R9 C restore pullup", portCPullUp, 8'hC3);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    @(negedge clk);
    sfrRead(8'h55, 1'b0, d); chk("R11 unmapped", d, 8'h00);
    sfrAddr = 8'h90; sfrRdEn = 1'b0;
    #1 chk("R11 no strobe", sfrRdData, 8'h00);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    @(negedge clk);
    sfrAddr = 8'hA0; sfrWrData = 8'h99; sfrWrEn = 1'b1; sfrRdEn = 1'b1;
    #1 chk("R12 old value", sfrRdData, 8'hC3);
    @(negedge clk);
    sfrWrEn = 1'b0; sfrRdEn = 1'b0;
    sfrRead(8'hA0, 1'b0, d); chk("R12 new value", d, 8'h99);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_write_read();
    t_read_pin();
    t_ext();
    t_unmapped();
    t_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule